// File: doc/BRIEF.md
# Shared Interrupt Line Combiner

This block merges three interrupt causes onto one shareable, active-low, level-type interrupt line. The causes are a serial controller's interrupt code and two general-purpose pads. Each pad can be set up as an input of either polarity, or as an output that drives a fixed level. A status-and-enable register shows the live state of each cause and gates it. A request from an enabled cause pulls the line low. The line stays low until software removes the condition or clears the enable.

An optional latched-event layer sits on top of the per-cause enables. It is bypassed after reset and is switched in by a control bit. While the layer is active, the line follows a latched event bit ANDed with a mask bit. A present-state register shows the live request. A force register lets software raise an event. All registers are reached through a simple single-cycle write port and a combinational read port.

Top module: `irq_combiner`

## Requirements
- R1: Each pad has a 2-bit setup field in the control register (address 0): pad 0 uses bits [1:0] and pad 1 uses bits [3:2]. The codes are: 00 plain input, 01 inverted input, 10 output driving 0, 11 output driving 1. For an output code, pin_oe is 1 and pin_out equals the field's low bit. For an input code, pin_oe is 0. The control register resets to 0.
- R2: The status-enable register (address 1) shows each pad's internal state, pad 0 at bit 9 and pad 1 at bit 10. For an input code the state is the pad value XOR the field's low bit. For an output code the state reads 0.
- R3: Bit 8 of the status-enable register reads as the inverse of bit 0 of uart_code, so it is 1 when the serial controller has an interrupt pending.
- R4: Bits [2:0] of the status-enable register are the enables: bit 0 for the serial controller, bit 1 for pad 0, bit 2 for pad 1. All three reset to 1. A cause asserts the line only when its enable is set. A pad set up as an output never asserts it.
- R5: With the layer bypassed, irq_pull is 1 (line driven low) in the same cycle in which any enabled cause is active. It stays 1 until the cause goes away or its enable is cleared, and it is 0 (line released) otherwise.
- R6: Bit 4 of the control register switches the event layer in. It resets to 0, so the layer is bypassed after reset.
- R7: With the layer active, irq_pull equals mask bit 0 (address 3) AND event bit 0 (address 2). The mask resets to 0.
- R8: Event bit 0 is set one clock after any enabled cause is active, and it then holds. Writing 1 to event bit 0 clears it, unless an enabled cause is active in that same cycle, in which case it stays set. Writing 0 has no effect.
- R9: The present-state register (address 4) bit 0 shows the live, unlatched request, whether the layer is active or not.
- R10: Writing 1 to bit 0 of the force register (address 5) sets event bit 0 one clock later. The force register always reads 0.
- R11: Reading any register changes no state. Bits without a defined function read 0, and addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register word address |
| reg_we | input | 1 | Write strobe, one write per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| uart_code | input | 4 | Serial controller interrupt source code; bit 0 = 1 means none pending |
| pin_in | input | 2 | Pad input values |
| pin_oe | output | 2 | Pad output enables |
| pin_out | output | 2 | Pad output values |
| irq_pull | output | 1 | 1 = drive the shared line low |

## Verification
The assertions assume that uart_code and pin_in are already synchronous to clk and change only between edges. They also assume that a write and a cause change landing in the same cycle obey the set-wins rule for the event bit. The bench changes every input on the falling edge and reads results after a settling delay. It sweeps every setup code of both pads, both pad levels, all enable masks and both serial-controller states with the layer bypassed. It then steps the layer through latching, masking, clearing, clear-while-active and force cases.

// File: rtl/irq_combiner.sv
module irq_combiner #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_we,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic [3:0]    uart_code,
  input  logic [1:0]    pin_in,
  output logic [1:0]    pin_oe,
  output logic [1:0]    pin_out,
  output logic          irq_pull
);
  localparam logic [AW-1:0] A_CTRL  = AW'(0);
  localparam logic [AW-1:0] A_STEN  = AW'(1);
  localparam logic [AW-1:0] A_EVENT = AW'(2);
  localparam logic [AW-1:0] A_MASK  = AW'(3);
  localparam logic [AW-1:0] A_PRES  = AW'(4);
  localparam logic [AW-1:0] A_FORCE = AW'(5);
  localparam int NPAD = 2;

  logic [2*NPAD-1:0] pcfg;
  logic              layer_en;
  logic [NPAD:0]     en;
  logic              ev_q, mask_q;
  logic [NPAD-1:0]   pst;
  logic              req;

  for (genvar i = 0; i < NPAD; i++) begin : g_pad
    assign pin_oe[i]  = pcfg[2*i+1];
    assign pin_out[i] = pcfg[2*i+1] & pcfg[2*i];
    assign pst[i]     = ~pcfg[2*i+1] & (pin_in[i] ^ pcfg[2*i]);
  end

  assign req = |({pst, ~uart_code[0]} & en);

  wire wr_ctrl  = reg_we && reg_addr == A_CTRL;
  wire wr_sten  = reg_we && reg_addr == A_STEN;
  wire ev_clr   = reg_we && reg_addr == A_EVENT && reg_wdata[0];
  wire wr_mask  = reg_we && reg_addr == A_MASK;
  wire ev_force = reg_we && reg_addr == A_FORCE && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcfg     <= '0;
      layer_en <= 1'b0;
      en       <= '1;
      ev_q     <= 1'b0;
      mask_q   <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        pcfg     <= reg_wdata[2*NPAD-1:0];
        layer_en <= reg_wdata[4];
      end
      if (wr_sten) en <= reg_wdata[NPAD:0];
      if (wr_mask) mask_q <= reg_wdata[0];
      if (req || ev_force) ev_q <= 1'b1;
      else if (ev_clr)     ev_q <= 1'b0;
    end
  end

  assign irq_pull = layer_en ? (mask_q & ev_q) : req;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  begin reg_rdata[2*NPAD-1:0] = pcfg; reg_rdata[4] = layer_en; end
      A_STEN:  begin
        reg_rdata[NPAD:0]     = en;
        reg_rdata[8]          = ~uart_code[0];
        reg_rdata[9+:NPAD]    = pst;
      end
      A_EVENT: reg_rdata[0] = ev_q;
      A_MASK:  reg_rdata[0] = mask_q;
      A_PRES:  reg_rdata[0] = req;
      default: reg_rdata = '0;
    endcase
  end

  assert_event_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> ev_q);
  assert_event_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_q && !ev_clr) |=> ev_q);
  assert_force_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_force |=> ev_q);
  assert_layer_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (layer_en && !ev_q) |-> !irq_pull);
  assert_uart_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!layer_en && en[0] && !uart_code[0]) |-> irq_pull);
endmodule

// File: tb/test_irq_combiner.sv
module test_irq_combiner;
  logic clk = 0, rst_n = 0;
  logic [2:0] reg_addr = 0;
  logic reg_we = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [3:0] uart_code = 4'h1;
  logic [1:0] pin_in = 0, pin_oe, pin_out;
  logic irq_pull;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_combiner i_irq_combiner (.clk, .rst_n, .reg_addr, .reg_we, .reg_wdata,
    .reg_rdata, .uart_code, .pin_in, .pin_oe, .pin_out, .irq_pull);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1;
    @(posedge clk); #1; reg_we = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #900000;
    n_bad++; n_cmp++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #1;
    rd(0, d); chk("R1 ctrl reset", d, 0);
    chk("R6 layer off at reset, bypass pin", {31'b0, irq_pull}, 0);
    rd(1, d); chk("R4 enables reset", d & 32'h7, 32'h7);
    rd(3, d); chk("R7 mask reset", d, 0);
    rd(2, d); chk("R8 event reset", d, 0);
    chk("R1 pads inputs at reset", {30'b0, pin_oe}, 0);
    @(negedge clk); rst_n = 1;

    for (int cfg = 0; cfg < 16; cfg++)
      for (int en = 0; en < 8; en++) begin
        wr(0, cfg);
        wr(1, en);
        for (int p = 0; p < 4; p++)
          for (int u = 0; u < 2; u++) begin
            logic [1:0] st, oe, ov;
            logic rq;
            @(negedge clk); pin_in = p[1:0]; uart_code = {3'b101, u[0]};
            for (int k = 0; k < 2; k++) begin
              logic [1:0] c;
              c = 2'((cfg >> (2*k)) & 3);
              oe[k] = c[1];
              ov[k] = c[1] & c[0];
              st[k] = c[1] ? 1'b0 : (p[k] ^ c[0]);
            end
            rq = |({st, ~u[0]} & en[2:0]);
            rd(1, d);
            chk("R2 R3 R4 status-enable read", d, {21'b0, st, ~u[0], 5'b0, en[2:0]});
            chk("R5 bypass line", {31'b0, irq_pull}, {31'b0, rq});
            chk("R1 pad drive", {28'b0, pin_oe, pin_out}, {28'b0, oe, ov});
            rd(4, d); chk("R9 present", d, {31'b0, rq});
          end
      end

    // event layer
    @(negedge clk); uart_code = 4'h1; pin_in = 0;
    wr(1, 1); wr(2, 1); wr(0, 32'h10);
    rd(2, d); chk("R8 event idle", d, 0);
    chk("R7 idle line", {31'b0, irq_pull}, 0);
    @(negedge clk); uart_code = 4'h0;
    #1; chk("R7 mask off no pull", {31'b0, irq_pull}, 0);
    @(posedge clk); #1;
    rd(2, d); chk("R8 event latched", d, 1);
    chk("R7 mask off still no pull", {31'b0, irq_pull}, 0);
    wr(3, 1);
    chk("R7 mask on pulls", {31'b0, irq_pull}, 1);
    @(negedge clk); uart_code = 4'h1;
    rd(4, d); chk("R9 present after removal", d, 0);
    rd(2, d); chk("R8 event holds", d, 1);
    rd(2, d); chk("R11 read no side effect", d, 1);
    wr(2, 0); rd(2, d); chk("R8 write 0 no effect", d, 1);
    wr(2, 1); rd(2, d); chk("R8 W1C clears", d, 0);
    chk("R7 released", {31'b0, irq_pull}, 0);
    @(negedge clk); uart_code = 4'h0;
    wr(2, 1); rd(2, d); chk("R8 clear while live stays", d, 1);
    @(negedge clk); uart_code = 4'h1;
    wr(2, 1); rd(2, d); chk("R8 cleared after removal", d, 0);
    wr(5, 1); rd(2, d); chk("R10 force sets event", d, 1);
    chk("R10 force pulls line", {31'b0, irq_pull}, 1);
    rd(5, d); chk("R10 force reads 0", d, 0);
    rd(6, d); chk("R11 unused addr 6", d, 0);
    rd(7, d); chk("R11 unused addr 7", d, 0);
    wr(0, 0);
    chk("R6 bypass again, no source", {31'b0, irq_pull}, 0);
    finish_run();
  end
endmodule